// File: doc/BRIEF.md
# Sample Statistics and Histogram Accumulator

This block sits beside a stream of signed ADC samples and observes it without altering or delaying it. Over each integration period it gathers the smallest and largest sample, the number of valid samples, the signed running sum and the sum of squares. It also keeps one counter per possible sample code, which gives a full histogram. Host software derives the mean and the RMS level from these values; the block computes no division or square root.

An integration period ends when the host pulses a cycle-end strobe. On that clock edge every live result moves into a readout bank, and the live accumulators restart. Software then fetches the readout bank through a word-addressed read port while the next period accumulates. Widths are parameters: sample width `SMP_W` (default 8), counter width `CNT_W` (default 32), sum width `SUM_W` (default 40), square-sum width `SQ_W` (default 48) and read width `RD_W` (default 32).

Top module: `adc_stat_gather`

## Requirements
- R1: After a period closes, address 256 reads the smallest and address 257 reads the largest valid sample of that period. Samples are two's complement `SMP_W`-bit codes, and both values are sign-extended to `RD_W` bits.
- R2: A period with no valid sample reads +127 (0x0000007F) as its minimum and -128 (0xFFFFFF80) as its maximum.
- R3: Address 258 reads the number of valid samples in the closed period. A cycle with `smp_valid` low adds nothing to any result.
- R4: Address 259 reads bits 31:0 of the signed sum of the period's samples. Address 260 reads the sum's bits above 31, sign-extended to 32 bits.
- R5: Address 261 reads bits 31:0 of the sum of squared samples. Address 262 reads the bits above 31, zero-extended.
- R6: Addresses 0 to 255 read histogram bins. The bin address of a sample is its code plus 128, which is the sample bits with the top bit inverted: -128 maps to 0, 0 maps to 128 and 127 maps to 255.
- R7: The sample count and every histogram bin stop at 2^`CNT_W`-1 and do not wrap.
- R8: A sample presented in the same cycle as `cyc_end` counts in the period that closes. The period after the strobe starts from empty, with the minimum at +127, the maximum at -128 and all counts and sums at zero.
- R9: The readout bank changes only on a `cyc_end` edge. Samples taken between strobes do not change what is read.
- R10: `rd_data` is registered. It shows the word at the `rd_addr` that was present at the previous rising edge. Addresses 263 to 511 read zero.
- R11: After reset, the readout bank reads minimum +127, maximum -128 and zero for every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | SMP_W | Two's complement sample code |
| cyc_end | input | 1 | Closes the integration period on this edge |
| rd_addr | input | SMP_W+1 | Readout word address |
| rd_data | output | RD_W | Readout word, one cycle after the address |

## Verification
The hardest state to reach from the ports is a saturated counter, because with 32-bit counters it would take billions of samples. The bench therefore builds the block with `CNT_W` set to 10 and drives 1030 equal samples. This pushes both the sample count and one bin past their ceiling, and the bench checks that both hold at 1023. A second hard case is a sample that arrives together with the strobe: the stimulus table places its last sample on the `cyc_end` cycle and expects it in the closed bank, then checks that the next period starts empty.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // Word selectors in the upper half of the readout address space
   typedef enum logic [2:0] {
      SEL_MIN  = 3'd0,
      SEL_MAX  = 3'd1,
      SEL_CNT  = 3'd2,
      SEL_SUML = 3'd3,
      SEL_SUMH = 3'd4,
      SEL_SQL  = 3'd5,
      SEL_SQH  = 3'd6
   } stat_sel_e;
endpackage

// File: rtl/stat_extrema.sv
module stat_extrema #(
   parameter int SMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             cyc_end,
   output logic [SMP_W-1:0] live_min,
   output logic [SMP_W-1:0] live_max,
   output logic [SMP_W-1:0] shd_min,
   output logic [SMP_W-1:0] shd_max
);
   localparam logic [SMP_W-1:0] TOP_CODE = {1'b0, {(SMP_W-1){1'b1}}};
   localparam logic [SMP_W-1:0] BOT_CODE = {1'b1, {(SMP_W-1){1'b0}}};

   logic [SMP_W-1:0] min_nxt, max_nxt;

   always_comb begin
      min_nxt = live_min;
      max_nxt = live_max;
      if (smp_valid) begin
         if ($signed(smp_data) < $signed(live_min)) min_nxt = smp_data;
         if ($signed(smp_data) > $signed(live_max)) max_nxt = smp_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_min <= TOP_CODE;
         live_max <= BOT_CODE;
         shd_min  <= TOP_CODE;
         shd_max  <= BOT_CODE;
      end else if (cyc_end) begin
         shd_min  <= min_nxt;
         shd_max  <= max_nxt;
         live_min <= TOP_CODE;
         live_max <= BOT_CODE;
      end else begin
         live_min <= min_nxt;
         live_max <= max_nxt;
      end
   end
endmodule

// File: rtl/stat_moments.sv
module stat_moments #(
   parameter int SMP_W = 8,
   parameter int CNT_W = 32,
   parameter int SUM_W = 40,
   parameter int SQ_W  = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             cyc_end,
   output logic [CNT_W-1:0] live_cnt,
   output logic [CNT_W-1:0] shd_cnt,
   output logic [SUM_W-1:0] shd_sum,
   output logic [SQ_W-1:0]  shd_sq
);
   localparam int          PROD_W  = 2 * SMP_W;
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [SUM_W-1:0]         live_sum, sum_nxt, d_ext;
   logic [SQ_W-1:0]          live_sq, sq_nxt, p_ext;
   logic [CNT_W-1:0]         cnt_nxt;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      d_ext = {SUM_W{smp_data[SMP_W-1]}};
      d_ext[SMP_W-1:0] = smp_data;
      prod  = $signed(smp_data) * $signed(smp_data);
      p_ext = '0;
      p_ext[PROD_W-1:0] = prod;
      cnt_nxt = live_cnt;
      sum_nxt = live_sum;
      sq_nxt  = live_sq;
      if (smp_valid) begin
         if (live_cnt != CNT_TOP) cnt_nxt = live_cnt + 1'b1;
         sum_nxt = live_sum + d_ext;
         sq_nxt  = live_sq + p_ext;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_cnt <= '0;
         live_sum <= '0;
         live_sq  <= '0;
         shd_cnt  <= '0;
         shd_sum  <= '0;
         shd_sq   <= '0;
      end else if (cyc_end) begin
         shd_cnt  <= cnt_nxt;
         shd_sum  <= sum_nxt;
         shd_sq   <= sq_nxt;
         live_cnt <= '0;
         live_sum <= '0;
         live_sq  <= '0;
      end else begin
         live_cnt <= cnt_nxt;
         live_sum <= sum_nxt;
         live_sq  <= sq_nxt;
      end
   end
endmodule

// File: rtl/stat_hist.sv
module stat_hist #(
   parameter int SMP_W = 8,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             cyc_end,
   input  logic [SMP_W-1:0] rd_bin,
   output logic [CNT_W-1:0] rd_val
);
   localparam int               NBINS   = 1 << SMP_W;
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   // Offset-binary bin index: code + half range
   logic [SMP_W-1:0] bin_idx;
   logic [CNT_W-1:0] shd_arr [NBINS];

   assign bin_idx = {~smp_data[SMP_W-1], smp_data[SMP_W-2:0]};

   for (genvar g = 0; g < NBINS; g++) begin : g_bin
      logic             hit;
      logic [CNT_W-1:0] live_q, shd_q, nxt;

      assign hit = smp_valid && (bin_idx == SMP_W'(g));
      assign nxt = (hit && live_q != CNT_TOP) ? live_q + 1'b1 : live_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= '0;
            shd_q  <= '0;
         end else if (cyc_end) begin
            shd_q  <= nxt;
            live_q <= '0;
         end else begin
            live_q <= nxt;
         end
      end

      assign shd_arr[g] = shd_q;
   end

   assign rd_val = shd_arr[rd_bin];
endmodule

// File: rtl/stat_readout.sv
module stat_readout
   import stat_pkg::*;
#(
   parameter int SMP_W = 8,
   parameter int CNT_W = 32,
   parameter int SUM_W = 40,
   parameter int SQ_W  = 48,
   parameter int RD_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SMP_W:0]    rd_addr,
   input  logic [CNT_W-1:0]  bin_val,
   input  logic [SMP_W-1:0]  shd_min,
   input  logic [SMP_W-1:0]  shd_max,
   input  logic [CNT_W-1:0]  shd_cnt,
   input  logic [SUM_W-1:0]  shd_sum,
   input  logic [SQ_W-1:0]   shd_sq,
   output logic [RD_W-1:0]   rd_data
);
   localparam int ADDR_W = SMP_W + 1;

   logic [RD_W-1:0] min_ext, max_ext, cnt_ext, bin_ext, sum_hi, sq_hi, word;

   always_comb begin
      min_ext = {RD_W{shd_min[SMP_W-1]}};
      min_ext[SMP_W-1:0] = shd_min;
      max_ext = {RD_W{shd_max[SMP_W-1]}};
      max_ext[SMP_W-1:0] = shd_max;
      cnt_ext = '0;
      cnt_ext[CNT_W-1:0] = shd_cnt;
      bin_ext = '0;
      bin_ext[CNT_W-1:0] = bin_val;
      sum_hi  = {RD_W{shd_sum[SUM_W-1]}};
      sum_hi[SUM_W-RD_W-1:0] = shd_sum[SUM_W-1:RD_W];
      sq_hi   = '0;
      sq_hi[SQ_W-RD_W-1:0] = shd_sq[SQ_W-1:RD_W];

      word = '0;
      if (!rd_addr[ADDR_W-1]) begin
         word = bin_ext;
      end else if (rd_addr[ADDR_W-2:3] == '0) begin
         case (stat_sel_e'(rd_addr[2:0]))
            SEL_MIN:  word = min_ext;
            SEL_MAX:  word = max_ext;
            SEL_CNT:  word = cnt_ext;
            SEL_SUML: word = shd_sum[RD_W-1:0];
            SEL_SUMH: word = sum_hi;
            SEL_SQL:  word = shd_sq[RD_W-1:0];
            SEL_SQH:  word = sq_hi;
            default:  word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= word;
   end
endmodule

// File: rtl/adc_stat_gather.sv
module adc_stat_gather #(
   parameter int SMP_W = 8,
   parameter int CNT_W = 32,
   parameter int SUM_W = 40,
   parameter int SQ_W  = 48,
   parameter int RD_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             cyc_end,
   input  logic [SMP_W:0]   rd_addr,
   output logic [RD_W-1:0]  rd_data
);
   // Elaboration-time parameter checks
   if (SMP_W < 4 || SMP_W > 10) begin : g_bad_smp
      $error("SMP_W must lie in 4..10");
   end
   if (CNT_W < 1 || CNT_W > RD_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..RD_W");
   end
   if (RD_W <= SMP_W) begin : g_bad_rd
      $error("RD_W must exceed SMP_W");
   end
   if (SUM_W <= RD_W || SUM_W > 2 * RD_W || SUM_W < SMP_W + CNT_W) begin : g_bad_sum
      $error("SUM_W must exceed RD_W, fit two words and hold SMP_W+CNT_W bits");
   end
   if (SQ_W <= RD_W || SQ_W > 2 * RD_W || SQ_W < 2 * SMP_W) begin : g_bad_sq
      $error("SQ_W must exceed RD_W, fit two words and hold a square");
   end

   logic [SMP_W-1:0] live_min, live_max, shd_min, shd_max;
   logic [CNT_W-1:0] live_cnt, shd_cnt, bin_val;
   logic [SUM_W-1:0] shd_sum;
   logic [SQ_W-1:0]  shd_sq;

   stat_extrema #(.SMP_W(SMP_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cyc_end(cyc_end), .live_min(live_min), .live_max(live_max),
      .shd_min(shd_min), .shd_max(shd_max)
   );

   stat_moments #(.SMP_W(SMP_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W)) u_mom (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cyc_end(cyc_end), .live_cnt(live_cnt), .shd_cnt(shd_cnt),
      .shd_sum(shd_sum), .shd_sq(shd_sq)
   );

   stat_hist #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cyc_end(cyc_end), .rd_bin(rd_addr[SMP_W-1:0]), .rd_val(bin_val)
   );

   stat_readout #(.SMP_W(SMP_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W),
                  .RD_W(RD_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .bin_val(bin_val),
      .shd_min(shd_min), .shd_max(shd_max), .shd_cnt(shd_cnt),
      .shd_sum(shd_sum), .shd_sq(shd_sq), .rd_data(rd_data)
   );
endmodule

// File: rtl/adc_stat_gather_chk.sv
module adc_stat_gather_chk #(
   parameter int SMP_W = 8,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             cyc_end,
   input logic [SMP_W-1:0] live_min,
   input logic [SMP_W-1:0] live_max,
   input logic [SMP_W-1:0] shd_min,
   input logic [CNT_W-1:0] live_cnt,
   input logic [CNT_W-1:0] shd_cnt
);
   localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
   localparam logic [SMP_W-1:0] TOP_CODE = {1'b0, {(SMP_W-1){1'b1}}};
   localparam logic [SMP_W-1:0] BOT_CODE = {1'b1, {(SMP_W-1){1'b0}}};

   AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt != '0) |-> ($signed(live_min) <= $signed(live_max))); // R1
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end |=> (live_cnt == '0 && live_min == TOP_CODE && live_max == BOT_CODE)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_end && live_cnt == CNT_TOP) |=> (live_cnt == CNT_TOP)); // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_end && smp_valid && live_cnt != CNT_TOP) |=>
      (live_cnt == CNT_W'($past(live_cnt) + 1'b1))); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_end && !smp_valid) |=> $stable(live_cnt)); // R3
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_end |=> ($stable(shd_cnt) && $stable(shd_min))); // R9
endmodule

bind adc_stat_gather adc_stat_gather_chk #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cyc_end(cyc_end),
   .live_min(live_min), .live_max(live_max), .shd_min(shd_min),
   .live_cnt(live_cnt), .shd_cnt(shd_cnt)
);

// File: tb/adc_stat_gather_test.sv
`timescale 1ns/100ps
module adc_stat_gather_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_data = '0;
   logic        cyc_end = 1'b0;
   logic [8:0]  rd_addr = '0;
   logic [31:0] rd_data;
   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   // Small counters so saturation is reachable
   adc_stat_gather #(.CNT_W(10)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cyc_end(cyc_end), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // {valid, cyc_end, sample}
   localparam logic [9:0] STIM [9] = '{
      {2'b10, 8'sd5}, {2'b10, -8'sd3}, {2'b10, 8'sd127}, {2'b00, 8'sd99},
      {2'b10, -8'sd128}, {2'b10, 8'sd0}, {2'b10, 8'sd5}, {2'b10, -8'sd1},
      {2'b11, 8'sd64}
   };
   // {address, expected word}
   localparam logic [40:0] EXPV [17] = '{
      {9'd256, 32'hFFFFFF80}, {9'd257, 32'd127}, {9'd258, 32'd8},
      {9'd259, 32'd69}, {9'd260, 32'd0}, {9'd261, 32'd36669}, {9'd262, 32'd0},
      {9'd133, 32'd2}, {9'd125, 32'd1}, {9'd255, 32'd1}, {9'd0, 32'd1},
      {9'd128, 32'd1}, {9'd127, 32'd1}, {9'd192, 32'd1}, {9'd134, 32'd0},
      {9'd227, 32'd0}, {9'd300, 32'd0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [8:0] a, input string tag, input logic [31:0] exp);
      @(negedge clk);
      rd_addr = a;
      @(negedge clk);
      check(tag, rd_data, exp);
   endtask

   task automatic put(input logic v, input logic e, input logic [7:0] d);
      @(negedge clk);
      smp_valid = v;
      cyc_end   = e;
      smp_data  = d;
   endtask

   initial begin
      #200000;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset readout
      rd(9'd256, "R11 min", 32'h0000007F);
      rd(9'd257, "R11 max", 32'hFFFFFF80);
      rd(9'd258, "R11 count", 32'd0);
      rd(9'd133, "R11 bin", 32'd0);

      // Table-driven period: R1 R3 R4 R5 R6 R8 R10
      for (int i = 0; i < 9; i++) put(STIM[i][9], STIM[i][8], STIM[i][7:0]);
      put(1'b0, 1'b0, 8'd0);
      for (int i = 0; i < 17; i++)
         rd(EXPV[i][40:32], "R1/R3/R4/R5/R6/R8/R10 table", EXPV[i][31:0]);
      rd(9'd263, "R10 unmapped", 32'd0);

      // Negative-only period; readout held until strobe (R9)
      put(1'b1, 1'b0, -8'sd5);
      put(1'b1, 1'b0, -8'sd7);
      put(1'b0, 1'b0, 8'd0);
      rd(9'd258, "R9 count held", 32'd8);
      rd(9'd133, "R9 bin held", 32'd2);
      put(1'b0, 1'b1, 8'd0);
      put(1'b0, 1'b0, 8'd0);
      rd(9'd256, "R1 neg min", 32'hFFFFFFF9);
      rd(9'd257, "R1 neg max", 32'hFFFFFFFB);
      rd(9'd258, "R3 neg count", 32'd2);
      rd(9'd259, "R4 neg sum low", 32'hFFFFFFF4);
      rd(9'd260, "R4 neg sum high", 32'hFFFFFFFF);
      rd(9'd261, "R5 neg sq", 32'd74);
      rd(9'd133, "R8 fresh bin", 32'd0);

      // Empty period (R2)
      put(1'b0, 1'b1, 8'd0);
      put(1'b0, 1'b0, 8'd0);
      rd(9'd256, "R2 empty min", 32'h0000007F);
      rd(9'd257, "R2 empty max", 32'hFFFFFF80);
      rd(9'd258, "R2 empty count", 32'd0);

      // Saturation with 10-bit counters (R7)
      for (int i = 0; i < 1030; i++) put(1'b1, 1'b0, 8'sd3);
      put(1'b0, 1'b1, 8'd0);
      put(1'b0, 1'b0, 8'd0);
      rd(9'd258, "R7 count sat", 32'd1023);
      rd(9'd131, "R7 bin sat", 32'd1023);
      rd(9'd259, "R7 sum exact", 32'd3090);
      rd(9'd261, "R7 sq exact", 32'd9270);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule